// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM

This block is a synthesizable on-chip memory with a read port and a write port that share one address bus. Each access that a port accepts moves four 36-bit words. The words travel on consecutive half-cycles of the notional input clock. The block runs on one clock at twice that rate. An input phase bit, `k_half`, marks which edges are primary (K) edges and which are secondary (K-bar) edges. The surrounding logic drives `k_half` high on every second edge, so that it alternates.

Storage is split into four sub-arrays, one per burst position. The address picks a group of four words. A write burst commits one word per edge and applies a 9-bit lane mask to each word. A read burst takes a snapshot of the whole group on its sampling edge. It presents that group two K cycles later, one word per edge, with a valid flag and an output enable.

Top module: `qdr_burst_sram`

## Requirements
- R1: `rd_sel_n` and `wr_sel_n` are active low and are sampled only on edges where `k_half` is 1. A low select on a `k_half`=0 edge starts nothing.
- R2: An accepted write commits four words on four successive edges. The first is the sampling edge. Beat b (0..3) goes to word b of the addressed group.
- R3: Each beat's `lane_we_n[i]`, sampled with that beat's `wdata`, controls bits [9i+8:9i]. When the bit is 0, those bits are written. When it is 1, the stored bits are kept and the input bits are ignored.
- R4: The address is taken only on the edge that starts a burst on a port. Its value on any other edge has no effect on either port.
- R5: Read beat 0 appears on `rdata` after the fourth edge following the read's sampling edge. Beats 1..3 follow on the next three edges.
- R6: Reads accepted on every second K edge produce an unbroken stream, with no idle edge between bursts.
- R7: A select on a port is ignored while that port's own burst is still in progress, which is the K edge two edges after the burst started.
- R8: A read returns the group as it stood before its sampling edge. No beat committed on that edge or later is visible, including beats of a write accepted on the same edge.
- R9: `rd_valid` and `rd_oe` are high exactly on the edges that carry burst data. `rdata` is 0 whenever `rd_oe` is low. If no burst follows, both drop at the first K edge after beat 3.
- R10: While `rst_n` is low, `rd_valid` and `rd_oe` are 0, `rdata` is 0, and both sequencers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; every rising edge is one beat |
| rst_n | input | 1 | Active-low synchronous reset |
| k_half | input | 1 | 1 on primary (K) edges, 0 on secondary edges |
| rd_sel_n | input | 1 | Active-low read start request |
| wr_sel_n | input | 1 | Active-low write start request |
| addr | input | AW | Shared group address, AW = log2(DEPTH/4) |
| wdata | input | WIDTH | Write word for the current beat |
| lane_we_n | input | LANES | Active-low per-lane write enables for the current beat |
| rdata | output | WIDTH | Read word, 0 when not driving |
| rd_oe | output | 1 | Read output driver enable |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench builds the block with a 36-bit word, four 9-bit lanes and a depth of 32 words, which gives eight groups. With so few groups, random addresses often land on a group that a write is committing at that moment. That makes same-edge and overlapping read/write pairs common, and those are the only cases where R8 shows a difference. The random stream also drives selects and addresses on secondary edges and on busy K edges, so R1, R4 and R7 are exercised throughout the run.

// File: rtl/qsram_pkg.sv
package qsram_pkg;
   localparam int unsigned BURST_LEN = 4;
   localparam int unsigned BEAT_W    = $clog2(BURST_LEN);
   typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/qsram_wr_seq.sv
module qsram_wr_seq
   import qsram_pkg::*;
#(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          k_half,
   input  logic          sel_n,
   input  logic [AW-1:0] addr,
   output logic          wr_en,
   output beat_t         beat,
   output logic [AW-1:0] grp
);
   beat_t         cnt;
   logic [AW-1:0] grp_q;
   logic          start;

   assign start = k_half && !sel_n && (cnt == '0);

   always_comb begin
      wr_en = start || (cnt != '0);
      beat  = start ? '0 : cnt;
      grp   = start ? addr : grp_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         grp_q <= '0;
      end else begin
         if (wr_en) cnt <= beat + 1'b1;
         if (start) grp_q <= addr;
      end
   end
endmodule

// File: rtl/qsram_rd_seq.sv
module qsram_rd_seq
   import qsram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic k_half,
   input  logic sel_n,
   output logic start,
   output logic launch
);
   beat_t cnt;
   logic  pend;

   assign start  = k_half && !sel_n && (cnt == '0);
   assign launch = pend && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (start || cnt != '0) cnt <= cnt + 1'b1;
         if (start)       pend <= 1'b1;
         else if (launch) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/qsram_bank.sv
module qsram_bank #(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned GROUPS = 8,
   localparam int unsigned AW    = $clog2(GROUPS)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    wgrp,
   input  logic [WIDTH-1:0] wdata,
   input  logic [LANES-1:0] lane_n,
   input  logic [AW-1:0]    rgrp,
   output logic [WIDTH-1:0] rword
);
   logic [WIDTH-1:0] mem [GROUPS];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (we && !lane_n[i])
            mem[wgrp][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
   end

   assign rword = mem[rgrp];
endmodule

// File: rtl/qsram_rd_out.sv
module qsram_rd_out
   import qsram_pkg::*;
#(
   parameter int unsigned WIDTH = 36
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic                            launch,
   input  logic [BURST_LEN-1:0][WIDTH-1:0] words,
   output logic [WIDTH-1:0]                rdata,
   output logic                            oe,
   output logic                            valid
);
   logic [BURST_LEN-1:0][WIDTH-1:0] snap;
   logic [BURST_LEN-1:0][WIDTH-1:0] obuf;
   beat_t                           ocnt;

   always_ff @(posedge clk) begin
      if (start) snap <= words;
      if (launch) obuf <= snap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         oe    <= 1'b0;
         valid <= 1'b0;
         ocnt  <= '0;
      end else if (launch) begin
         rdata <= snap[0];
         oe    <= 1'b1;
         valid <= 1'b1;
         ocnt  <= beat_t'(1);
      end else if (ocnt != '0) begin
         rdata <= obuf[ocnt];
         ocnt  <= ocnt + 1'b1;
      end else begin
         rdata <= '0;
         oe    <= 1'b0;
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
   import qsram_pkg::*;
#(
   parameter int unsigned WIDTH  = 36,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned GROUPS = DEPTH / BURST_LEN,
   localparam int unsigned AW     = $clog2(GROUPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             k_half,
   input  logic             rd_sel_n,
   input  logic             wr_sel_n,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [LANES-1:0] lane_we_n,
   output logic [WIDTH-1:0] rdata,
   output logic             rd_oe,
   output logic             rd_valid
);
   initial begin
      if (WIDTH != LANES * LANE_W)
         $fatal(1, "lane split does not cover the word");
      if (GROUPS < 2 || (1 << AW) != GROUPS)
         $fatal(1, "depth must be a power of two of at least two bursts");
   end

   logic                            wr_en;
   beat_t                           wr_beat;
   logic [AW-1:0]                   wr_grp;
   logic                            rd_start;
   logic                            rd_launch;
   logic [BURST_LEN-1:0][WIDTH-1:0] bank_words;

   qsram_wr_seq #(.AW(AW)) u_wr (
      .clk(clk), .rst_n(rst_n), .k_half(k_half), .sel_n(wr_sel_n),
      .addr(addr), .wr_en(wr_en), .beat(wr_beat), .grp(wr_grp)
   );

   qsram_rd_seq u_rd (
      .clk(clk), .rst_n(rst_n), .k_half(k_half), .sel_n(rd_sel_n),
      .start(rd_start), .launch(rd_launch)
   );

   for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_en && (wr_beat == beat_t'(b));
      qsram_bank #(
         .WIDTH(WIDTH), .LANES(LANES), .LANE_W(LANE_W), .GROUPS(GROUPS)
      ) u_bank (
         .clk(clk), .we(bank_we), .wgrp(wr_grp), .wdata(wdata),
         .lane_n(lane_we_n), .rgrp(addr), .rword(bank_words[b])
      );
   end

   qsram_rd_out #(.WIDTH(WIDTH)) u_out (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .launch(rd_launch),
      .words(bank_words), .rdata(rdata), .oe(rd_oe), .valid(rd_valid)
   );
endmodule

// File: rtl/qsram_chk.sv
module qsram_chk
   import qsram_pkg::*;
#(
   parameter int unsigned WIDTH = 36
) (
   input logic             clk,
   input logic             rst_n,
   input logic             k_half,
   input logic             rd_start,
   input logic             wr_en,
   input beat_t            wr_beat,
   input logic             rd_valid,
   input logic             rd_oe,
   input logic [WIDTH-1:0] rdata
);
   assert_rd_on_k_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> k_half);

   assert_rd_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !rd_start);

   assert_wr_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_beat != beat_t'(BURST_LEN-1)) |=>
         (wr_en && wr_beat == beat_t'($past(wr_beat) + 1'b1)));

   assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |-> ##5 rd_valid);

   assert_valid_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_oe);

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> (rdata == '0));

   assert_rise_k_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> !k_half);
endmodule

bind qdr_burst_sram qsram_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .k_half(k_half), .rd_start(rd_start),
   .wr_en(wr_en), .wr_beat(wr_beat), .rd_valid(rd_valid), .rd_oe(rd_oe),
   .rdata(rdata)
);

// File: tb/tb_qdr_burst_sram.sv
module tb_qdr_burst_sram;
   localparam int WIDTH  = 36;
   localparam int LANES  = 4;
   localparam int LANE_W = 9;
   localparam int DEPTH  = 32;
   localparam int AW     = $clog2(DEPTH / 4);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             k_half = 1'b0;
   logic             rd_sel_n = 1'b1;
   logic             wr_sel_n = 1'b1;
   logic [AW-1:0]    addr = '0;
   logic [WIDTH-1:0] wdata = '0;
   logic [LANES-1:0] lane_we_n = '1;
   logic [WIDTH-1:0] rdata;
   logic             rd_oe;
   logic             rd_valid;

   qdr_burst_sram #(.WIDTH(WIDTH), .LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .k_half(k_half), .rd_sel_n(rd_sel_n),
      .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .lane_we_n(lane_we_n),
      .rdata(rdata), .rd_oe(rd_oe), .rd_valid(rd_valid)
   );

   int passed = 0;
   int total  = 0;
   int n      = 0;

   task automatic chk(input bit ok, input string what, input logic [WIDTH-1:0] act,
                      input logic [WIDTH-1:0] exp);
      total++;
      if (ok) passed++;
      else $display("FAIL %s at edge %0d: actual %h expected %h", what, n, act, exp);
   endtask

   // Reference model: word-addressed array, expected-output map keyed by edge index.
   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] expq [int];
   int               rcnt = 0;
   int               wcnt = 0;
   int               wgrp = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         n++;
         if (k_half && !rd_sel_n && rcnt == 0) begin
            for (int b = 0; b < 4; b++) expq[n + 4 + b] = mem[int'(addr) * 4 + b];
            rcnt = 3;
         end else if (rcnt > 0) rcnt--;
         begin
            int beat;
            bit act;
            act = 1'b0;
            beat = 0;
            if (wcnt == 0 && k_half && !wr_sel_n) begin
               wgrp = int'(addr); beat = 0; wcnt = 3; act = 1'b1;
            end else if (wcnt > 0) begin
               beat = 4 - wcnt; wcnt--; act = 1'b1;
            end
            if (act)
               for (int i = 0; i < LANES; i++)
                  if (!lane_we_n[i])
                     mem[wgrp * 4 + beat][i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && n > 0) begin
         if (expq.exists(n)) begin
            chk(rd_valid === 1'b1, "R9 valid during burst", WIDTH'(rd_valid), 1);
            chk(rd_oe === 1'b1, "R9 oe during burst", WIDTH'(rd_oe), 1);
            chk(rdata === expq[n], "R1 R2 R3 R4 R5 R6 R7 R8 read data", rdata, expq[n]);
            expq.delete(n);
         end else begin
            chk(rd_valid === 1'b0, "R9 valid idle", WIDTH'(rd_valid), 0);
            chk(rd_oe === 1'b0, "R9 oe idle", WIDTH'(rd_oe), 0);
            chk(rdata === '0, "R9 rdata idle", rdata, 0);
         end
      end
   end

   function automatic logic [WIDTH-1:0] rnd_word();
      return WIDTH'({$urandom, $urandom});
   endfunction

   task automatic half(input bit kh, input bit rs, input bit ws, input int a,
                       input logic [WIDTH-1:0] d, input logic [LANES-1:0] m);
      @(negedge clk);
      k_half    = kh;
      rd_sel_n  = rs;
      wr_sel_n  = ws;
      addr      = AW'(a);
      wdata     = d;
      lane_we_n = m;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", passed, total);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R10 watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(rd_valid === 1'b0, "R10 reset valid", WIDTH'(rd_valid), 0);
      chk(rd_oe === 1'b0, "R10 reset oe", WIDTH'(rd_oe), 0);
      chk(rdata === '0, "R10 reset rdata", rdata, 0);
      rst_n = 1'b1;

      // R2: fill every group with full-mask writes; write select held low on the busy K edge (R7)
      for (int g = 0; g < DEPTH / 4; g++) begin
         half(1, 1, 0, g, rnd_word(), '0);
         half(0, 0, 0, $urandom_range(0, 7), rnd_word(), '0);   // R1: K-bar selects ignored
         half(1, 1, 0, $urandom_range(0, 7), rnd_word(), '0);   // R4, R7
         half(0, 1, 1, $urandom_range(0, 7), rnd_word(), '0);
      end

      // R5, R6: back-to-back reads; R7: read select low on busy K edge
      for (int g = 0; g < DEPTH / 4; g++) begin
         half(1, 0, 1, g, rnd_word(), '1);
         half(0, 1, 1, 0, rnd_word(), '1);
         half(1, 0, 1, (g + 3) % 8, rnd_word(), '1);
         half(0, 1, 1, 0, rnd_word(), '1);
      end

      // R8: read and write of the same group on one K edge; R3: partial lane masks
      half(1, 0, 0, 2, rnd_word(), 4'b0101);
      half(0, 1, 1, 5, rnd_word(), 4'b1010);
      half(1, 1, 1, 5, rnd_word(), 4'b0000);
      half(0, 1, 1, 5, rnd_word(), 4'b1111);
      half(1, 0, 1, 2, rnd_word(), '1);
      half(0, 1, 1, 0, rnd_word(), '1);

      // Random mix on both ports
      for (int i = 0; i < 1600; i++) begin
         half(i % 2 == 0, $urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0,
              $urandom_range(0, 7), rnd_word(), LANES'($urandom));
      end

      // Drain
      for (int i = 0; i < 16; i++) half(i % 2 == 0, 1, 1, 0, '0, '1);
      summary();
   end
endmodule